// File: doc/BRIEF.md
# Indirect Pattern Detector

This block learns the address law behind an indirect access stream. A trained stream reads index values out of memory and then touches `base + (index << shift)`. The detector holds one candidate stream at a time and finds the unknown base and shift from cache misses. It needs no prior knowledge of either value.

When an index is read for a stream, the detector is armed. Each later cache miss is turned into a row of base guesses, one per allowed shift, by subtracting the shifted index from the miss address. When the same stream delivers a second index, later misses are turned into guesses with the new index, and those guesses are compared against the stored rows. A hit proves both base and shift. The detector then sends a one-cycle enable command that names the owning prefetch-table entry. That command is consumed by a separate confidence stage. Issuing prefetches happens elsewhere.

The comparison walks the stored rows one per cycle. While it runs, the block raises `busy_o` and accepts neither misses nor index events.

Top module: `indir_pattern_finder`

## Requirements
- R1: An index event is accepted only when `idx_valid_i` is high, `busy_o` is low, `idx_hit_i` is 1, `idx_write_i` is 0 and `idx_size_i` is 1, 2, 4 or 8. Any other index event leaves the detector state unchanged.
- R2: With the default byte order, the index is made from data bytes 0 to size−1. Byte k sits at `idx_data_i[8k+7:8k]` and byte 0 is the least significant. The result is zero-extended to the address width before shifting.
- R3: An accepted index from an entry that does not own the slot, or arriving while the slot is free, claims the slot for that entry. It stores the value as the first index, clears the recorded rows and starts miss tracking.
- R4: A second accepted index from the owning entry stores the second index and keeps miss tracking on. This holds even when the row store had filled and tracking had stopped.
- R5: A third accepted index from the owning entry, arriving before any match, frees the slot and stops tracking. Misses after that produce no enable.
- R6: In first-index mode, each accepted miss records one row holding `miss − (idx1 << s)` for every configured shift s. Once ROWS rows exist, tracking stops and further misses are not recorded.
- R7: In second-index mode, a miss is compared in row order, and within a row in shift-list order. The first stored candidate equal to `miss − (idx2 << s)` of the same shift gives the base and shift. The defaults are shifts {2, 3} and 4 rows.
- R8: A miss accepted in second-index mode with n stored rows raises `busy_o` from the next cycle for at most n cycles, one row per cycle. `miss_ready_o` is low while busy or while `idx_valid_i` is high, and index events are ignored while busy.
- R9: On a match, `en_valid_o` pulses for one cycle in the cycle after the matching row is scanned. It carries the owner entry, base and shift. At the same edge `busy_o` falls, the slot is freed and tracking stops.
- R10: After reset, `busy_o` and `en_valid_o` are 0 and `miss_ready_o` is 1.
- R11: A miss that arrives with no tracking slot leaves `busy_o` low and produces no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| idx_valid_i | input | 1 | Index event strobe |
| idx_entry_i | input | EID_W | Prefetch-table entry that read the index |
| idx_data_i | input | 64 | Raw read data, byte lanes |
| idx_size_i | input | 4 | Access size in bytes |
| idx_write_i | input | 1 | Access was a write |
| idx_hit_i | input | 1 | Access hit in the cache |
| miss_valid_i | input | 1 | Miss address strobe |
| miss_addr_i | input | ADDR_W | Miss address |
| miss_ready_o | output | 1 | Miss can be taken this cycle |
| busy_o | output | 1 | Row comparison in progress |
| en_valid_o | output | 1 | Enable command pulse |
| en_entry_o | output | EID_W | Entry to enable |
| en_base_o | output | ADDR_W | Discovered base address |
| en_shift_o | output | 6 | Discovered shift |

## Verification
On every cycle the assertions check the scan and enable behaviour. Each enable is a single pulse that ends a scan and leaves the block idle. The reported shift is always one from the configured list. A scan starts only from an accepted miss and never runs longer than the row store depth.

The remaining behaviours can only be shown by the bench scenarios, because they depend on history built up over many events. These are the index qualification and byte assembly, slot take-over and release on a third index, the row-store limit, and the order in which rows and shifts are searched. The bench also confirms the computed base value, which the assertions do not check.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
   localparam int unsigned SH_W = 6;

   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_IDX1 = 2'd1,
      SLOT_IDX2 = 2'd2
   } slot_mode_e;

   function automatic logic size_is_index(input logic [3:0] sz);
      return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
   endfunction
endpackage

// File: rtl/ipf_index_extract.sv
module ipf_index_extract #(
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic        valid_i,
   input  logic        hit_i,
   input  logic        write_i,
   input  logic [3:0]  size_i,
   input  logic [63:0] data_i,
   output logic        ok_o,
   output logic [63:0] value_o
);
   import ipf_pkg::*;

   assign ok_o = valid_i && hit_i && !write_i && size_is_index(size_i);

   logic [7:0] b [8];
   for (genvar k = 0; k < 8; k++) begin : g_lane
      assign b[k] = data_i[8*k +: 8];
   end

   if (LSB_FIRST) begin : g_le
      always_comb begin
         unique case (size_i)
            4'd1:    value_o = {56'd0, b[0]};
            4'd2:    value_o = {48'd0, b[1], b[0]};
            4'd4:    value_o = {32'd0, b[3], b[2], b[1], b[0]};
            default: value_o = data_i;
         endcase
      end
   end else begin : g_be
      always_comb begin
         unique case (size_i)
            4'd1:    value_o = {56'd0, b[0]};
            4'd2:    value_o = {48'd0, b[0], b[1]};
            4'd4:    value_o = {32'd0, b[0], b[1], b[2], b[3]};
            default: value_o = {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
         endcase
      end
   end
endmodule

// File: rtl/ipf_base_calc.sv
module ipf_base_calc #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned NSHIFT    = 2,
   parameter logic [NSHIFT*ipf_pkg::SH_W-1:0] SHIFT_SET = {6'd3, 6'd2}
) (
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [ADDR_W-1:0]             idx_i,
   output logic [NSHIFT-1:0][ADDR_W-1:0] cand_o
);
   import ipf_pkg::*;

   for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
      localparam int unsigned SH = SHIFT_SET[s*SH_W +: SH_W];
      assign cand_o[s] = addr_i - (idx_i << SH);
   end
endmodule

// File: rtl/indir_pattern_finder.sv
module indir_pattern_finder #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned EID_W     = 4,
   parameter int unsigned ROWS      = 4,
   parameter int unsigned NSHIFT    = 2,
   parameter logic [NSHIFT*ipf_pkg::SH_W-1:0] SHIFT_SET = {6'd3, 6'd2},
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    idx_valid_i,
   input  logic [EID_W-1:0]        idx_entry_i,
   input  logic [63:0]             idx_data_i,
   input  logic [3:0]              idx_size_i,
   input  logic                    idx_write_i,
   input  logic                    idx_hit_i,
   input  logic                    miss_valid_i,
   input  logic [ADDR_W-1:0]       miss_addr_i,
   output logic                    miss_ready_o,
   output logic                    busy_o,
   output logic                    en_valid_o,
   output logic [EID_W-1:0]        en_entry_o,
   output logic [ADDR_W-1:0]       en_base_o,
   output logic [ipf_pkg::SH_W-1:0] en_shift_o
);
   import ipf_pkg::*;

   localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int unsigned CNT_W = $clog2(ROWS + 1);
   localparam int unsigned SEL_W = (NSHIFT > 1) ? $clog2(NSHIFT) : 1;

   if (ROWS < 2) begin : g_bad_rows
      $error("ROWS must be at least 2");
   end
   if (NSHIFT < 1) begin : g_bad_nshift
      $error("NSHIFT must be at least 1");
   end
   for (genvar s = 0; s < NSHIFT; s++) begin : g_chk_shift
      if (SHIFT_SET[s*SH_W +: SH_W] >= ADDR_W) begin : g_bad_shift
         $error("shift value exceeds address width");
      end
   end

   logic        idx_ok;
   logic [63:0] idx_raw;

   ipf_index_extract #(.LSB_FIRST(LSB_FIRST)) u_extract (
      .valid_i (idx_valid_i),
      .hit_i   (idx_hit_i),
      .write_i (idx_write_i),
      .size_i  (idx_size_i),
      .data_i  (idx_data_i),
      .ok_o    (idx_ok),
      .value_o (idx_raw)
   );

   slot_mode_e              mode_q;
   logic [EID_W-1:0]        owner_q;
   logic [ADDR_W-1:0]       idx1_q, idx2_q, scan_addr_q;
   logic                    track_q, busy_q;
   logic [CNT_W-1:0]        nrows_q;
   logic [ROW_W-1:0]        scan_row_q;
   logic [ADDR_W-1:0]       rows_q [ROWS][NSHIFT];

   logic [ADDR_W-1:0]             idx_val, calc_idx, calc_addr;
   logic [NSHIFT-1:0][ADDR_W-1:0] cand;

   assign idx_val   = ADDR_W'(idx_raw);
   assign calc_idx  = (mode_q == SLOT_IDX2) ? idx2_q : idx1_q;
   assign calc_addr = busy_q ? scan_addr_q : miss_addr_i;

   ipf_base_calc #(.ADDR_W(ADDR_W), .NSHIFT(NSHIFT), .SHIFT_SET(SHIFT_SET)) u_calc (
      .addr_i (calc_addr),
      .idx_i  (calc_idx),
      .cand_o (cand)
   );

   logic take_idx, take_miss, own_hit, row_hit, last_row;
   logic [SEL_W-1:0] hit_sel;

   assign take_idx     = idx_ok && !busy_q;
   assign miss_ready_o = !busy_q && !idx_valid_i;
   assign take_miss    = miss_valid_i && miss_ready_o;
   assign own_hit      = (mode_q != SLOT_FREE) && (owner_q == idx_entry_i);
   assign last_row     = (CNT_W'(scan_row_q) == nrows_q - CNT_W'(1));

   always_comb begin
      row_hit = 1'b0;
      hit_sel = '0;
      for (int s = NSHIFT - 1; s >= 0; s--) begin
         if (rows_q[scan_row_q][s] == cand[s]) begin
            row_hit = 1'b1;
            hit_sel = SEL_W'(s);
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q     <= SLOT_FREE;
         owner_q    <= '0;
         idx1_q     <= '0;
         idx2_q     <= '0;
         track_q    <= 1'b0;
         busy_q     <= 1'b0;
         nrows_q    <= '0;
         scan_row_q <= '0;
         en_valid_o <= 1'b0;
         en_entry_o <= '0;
         en_base_o  <= '0;
         en_shift_o <= '0;
      end else begin
         en_valid_o <= 1'b0;
         if (take_idx) begin
            if (own_hit && mode_q == SLOT_IDX1) begin
               idx2_q  <= idx_val;
               mode_q  <= SLOT_IDX2;
               track_q <= 1'b1;
            end else if (own_hit) begin
               mode_q  <= SLOT_FREE;
               track_q <= 1'b0;
            end else begin
               mode_q  <= SLOT_IDX1;
               owner_q <= idx_entry_i;
               idx1_q  <= idx_val;
               nrows_q <= '0;
               track_q <= 1'b1;
            end
         end else if (take_miss && track_q) begin
            if (mode_q == SLOT_IDX1) begin
               nrows_q <= nrows_q + CNT_W'(1);
               if (nrows_q + CNT_W'(1) == CNT_W'(ROWS)) track_q <= 1'b0;
            end else if (nrows_q != '0) begin
               busy_q     <= 1'b1;
               scan_row_q <= '0;
            end
         end else if (busy_q) begin
            if (row_hit) begin
               en_valid_o <= 1'b1;
               en_entry_o <= owner_q;
               en_base_o  <= rows_q[scan_row_q][hit_sel];
               en_shift_o <= SHIFT_SET[hit_sel*SH_W +: SH_W];
               mode_q     <= SLOT_FREE;
               track_q    <= 1'b0;
               busy_q     <= 1'b0;
            end else if (last_row) begin
               busy_q <= 1'b0;
            end else begin
               scan_row_q <= scan_row_q + ROW_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (take_miss && !take_idx && track_q && mode_q == SLOT_IDX1) begin
         for (int s = 0; s < NSHIFT; s++) begin
            rows_q[nrows_q[ROW_W-1:0]][s] <= cand[s];
         end
      end
      if (take_miss) scan_addr_q <= miss_addr_i;
   end

   assign busy_o = busy_q;
endmodule

// File: rtl/ipf_checker.sv
module ipf_checker #(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned NSHIFT = 2,
   parameter logic [NSHIFT*ipf_pkg::SH_W-1:0] SHIFT_SET = {6'd3, 6'd2}
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     miss_valid_i,
   input logic                     miss_ready_o,
   input logic                     busy_o,
   input logic                     en_valid_o,
   input logic [ipf_pkg::SH_W-1:0] en_shift_o
);
   import ipf_pkg::*;

   logic [15:0] busy_run;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     busy_run <= '0;
      else if (busy_o) busy_run <= busy_run + 16'd1;
      else             busy_run <= '0;
   end

   logic shift_legal;
   always_comb begin
      shift_legal = 1'b0;
      for (int s = 0; s < NSHIFT; s++) begin
         if (SHIFT_SET[s*SH_W +: SH_W] == en_shift_o) shift_legal = 1'b1;
      end
   end

   assert_scan_from_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(miss_valid_i && miss_ready_o));

   assert_scan_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (busy_run < 16'(ROWS)));

   assert_enable_ends_scan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_valid_o |-> ($past(busy_o) && !busy_o));

   assert_enable_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_valid_o |=> !en_valid_o);

   assert_enable_shift_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_valid_o |-> shift_legal);
endmodule

bind indir_pattern_finder ipf_checker #(
   .ROWS(ROWS), .NSHIFT(NSHIFT), .SHIFT_SET(SHIFT_SET)
) u_ipf_checker (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .miss_valid_i (miss_valid_i),
   .miss_ready_o (miss_ready_o),
   .busy_o       (busy_o),
   .en_valid_o   (en_valid_o),
   .en_shift_o   (en_shift_o)
);

// File: tb/indir_pattern_finder_tb_top.sv
module indir_pattern_finder_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idx_valid = 1'b0;
   logic [3:0]  idx_entry = '0;
   logic [63:0] idx_data = '0;
   logic [3:0]  idx_size = '0;
   logic        idx_write = 1'b0;
   logic        idx_hit = 1'b0;
   logic        miss_valid = 1'b0;
   logic [63:0] miss_addr = '0;
   logic        miss_ready, busy, en_valid;
   logic [3:0]  en_entry;
   logic [63:0] en_base;
   logic [5:0]  en_shift;

   int n_tests = 0;
   int n_fail  = 0;

   bit          got_en;
   logic [3:0]  got_entry;
   logic [63:0] got_base;
   logic [5:0]  got_shift;
   int          got_cycles;

   always #(CLK_PERIOD/2) clk = ~clk;

   indir_pattern_finder dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .idx_valid_i(idx_valid), .idx_entry_i(idx_entry), .idx_data_i(idx_data),
      .idx_size_i(idx_size), .idx_write_i(idx_write), .idx_hit_i(idx_hit),
      .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
      .miss_ready_o(miss_ready), .busy_o(busy),
      .en_valid_o(en_valid), .en_entry_o(en_entry),
      .en_base_o(en_base), .en_shift_o(en_shift)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic send_idx(input logic [3:0] e, input logic [63:0] d,
                           input logic [3:0] sz, input bit wr, input bit hit);
      @(negedge clk);
      idx_valid = 1'b1; idx_entry = e; idx_data = d;
      idx_size = sz; idx_write = wr; idx_hit = hit;
      @(negedge clk);
      idx_valid = 1'b0;
   endtask

   task automatic send_miss(input logic [63:0] a, input bit poke);
      got_en = 1'b0; got_cycles = 0;
      @(negedge clk);
      miss_valid = 1'b1; miss_addr = a;
      @(negedge clk);
      miss_valid = 1'b0;
      while (busy) begin
         if (poke && got_cycles == 0) begin
            idx_valid = 1'b1; idx_entry = 4'd4; idx_data = 64'd7;
            idx_size = 4'd8; idx_write = 1'b0; idx_hit = 1'b1;
         end
         @(negedge clk);
         idx_valid = 1'b0;
         got_cycles++;
         if (en_valid) begin
            got_en = 1'b1; got_entry = en_entry;
            got_base = en_base; got_shift = en_shift;
         end
      end
   endtask

   task automatic expect_none(input string req, input int cyc);
      check(!got_en, req, 64'(got_en), 64'd0);
      check(got_cycles == cyc, req, 64'(got_cycles), 64'(cyc));
   endtask

   task automatic expect_en(input string req, input logic [3:0] e, input logic [63:0] base,
                            input logic [5:0] sh, input int cyc);
      check(got_en, req, 64'(got_en), 64'd1);
      check(got_entry == e, req, 64'(got_entry), 64'(e));
      check(got_base == base, req, got_base, base);
      check(got_shift == sh, req, 64'(got_shift), 64'(sh));
      check(got_cycles == cyc, req, 64'(got_cycles), 64'(cyc));
   endtask

   task automatic test_reset;
      @(negedge clk);
      check(busy == 1'b0, "R10 busy", 64'(busy), 64'd0);
      check(en_valid == 1'b0, "R10 en_valid", 64'(en_valid), 64'd0);
      check(miss_ready == 1'b1, "R10 miss_ready", 64'(miss_ready), 64'd1);
   endtask

   task automatic test_idle_miss;
      send_miss(64'h40, 1'b0);
      expect_none("R11 miss without slot", 0);
   endtask

   task automatic test_basic_ignore;
      send_idx(4'd3, 64'hDEAD_BEEF_1234_000A, 4'd2, 1'b0, 1'b1);
      send_idx(4'd5, 64'd7, 4'd2, 1'b1, 1'b1);
      send_idx(4'd5, 64'd7, 4'd3, 1'b0, 1'b1);
      send_idx(4'd5, 64'd7, 4'd2, 1'b0, 1'b0);
      send_miss(64'h1050, 1'b0);
      expect_none("R6 idx1 miss records", 0);
      send_idx(4'd3, 64'hFFFF_FFFF_0000_000C, 4'd4, 1'b0, 1'b1);
      send_miss(64'h1060, 1'b0);
      expect_en("R1 R2 R4 R7 basic match", 4'd3, 64'h1000, 6'd3, 1);
      send_miss(64'h1060, 1'b0);
      expect_none("R9 slot freed after match", 0);
   endtask

   task automatic test_third_index;
      send_idx(4'd2, 64'd4, 4'd8, 1'b0, 1'b1);
      send_miss(64'h1FF8, 1'b0);
      send_idx(4'd2, 64'd5, 4'd8, 1'b0, 1'b1);
      send_idx(4'd2, 64'd6, 4'd8, 1'b0, 1'b1);
      send_miss(64'h2000, 1'b0);
      expect_none("R5 third index frees slot", 0);
   endtask

   task automatic test_priority;
      send_idx(4'd9, 64'd99, 4'd8, 1'b0, 1'b1);
      send_idx(4'd4, 64'd4, 4'd8, 1'b0, 1'b1);
      send_miss(64'h1FF8, 1'b0);
      send_miss(64'h1FFC, 1'b0);
      send_idx(4'd4, 64'hFFFF_FFFF_FFFF_FF05, 4'd1, 1'b0, 1'b1);
      send_miss(64'h9000, 1'b1);
      expect_none("R8 full scan no match, index ignored while busy", 2);
      send_miss(64'h2000, 1'b0);
      expect_en("R3 R7 row order first match", 4'd4, 64'h1FD8, 6'd3, 1);
   endtask

   task automatic test_shift_order;
      send_idx(4'd8, 64'd7, 4'd8, 1'b0, 1'b1);
      send_miss(64'h3000, 1'b0);
      send_idx(4'd8, 64'd7, 4'd8, 1'b0, 1'b1);
      send_miss(64'h3000, 1'b0);
      expect_en("R7 shift list order", 4'd8, 64'h2FE4, 6'd2, 1);
   endtask

   task automatic test_rows_full;
      send_idx(4'd1, 64'd1, 4'd8, 1'b0, 1'b1);
      send_miss(64'h100, 1'b0);
      send_miss(64'h200, 1'b0);
      send_miss(64'h300, 1'b0);
      send_miss(64'h400, 1'b0);
      send_miss(64'h5000, 1'b0);
      send_idx(4'd1, 64'd2, 4'd8, 1'b0, 1'b1);
      send_miss(64'h5008, 1'b0);
      expect_none("R6 fifth miss not recorded", 4);
      send_miss(64'h208, 1'b0);
      expect_en("R4 R8 match in second row", 4'd1, 64'h1F8, 6'd3, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset;
      rst_n = 1'b1;
      test_reset;
      test_idle_miss;
      test_basic_ignore;
      test_third_index;
      test_priority;
      test_shift_order;
      test_rows_full;
      repeat (3) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule